// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block loads a configuration bitstream into a target FPGA over a passive serial link. A start pulse opens the sequence. The block holds the system bus reset low for the whole run. It pulses the active-low configuration request, and waits for the target's active-low status line to fall and then rise again. It then shifts the bitstream out one bit per data clock. Bytes arrive from a host over a valid/ready byte stream, and a last flag marks the end of the stream.

After the final byte, the block keeps clocking zeros until the target's configuration-done input goes high. It then issues a fixed number of wake-up clocks and reports success. If the target is not ready in time, or does not signal done in time, the block stops and reports which of the two waits failed. The data clock runs at a rate set by a divider value, which the block captures at start.

Top module: `serial_cfg_loader`

## Requirements
- R1: `bus_rst_n` is low from the cycle after a start is accepted until `busy` falls, and high while idle.
- R2: After start, `cfg_req_n` stays high for exactly LONG_DLY cycles, then goes low for at least SHORT_DLY cycles.
- R3: `cfg_req_n` is released only after `status_n`, through a two-flop synchronizer, reads low. This wait has no time limit.
- R4: After release, the block waits for the synchronized `status_n` to read high. If it does not within READY_TMO cycles, the run ends with `error` = 2'b01, `done_ok` = 0 and no data clock pulses.
- R5: Each byte is sent least significant bit first, one bit per rising edge of `dclk`, eight pulses per byte. Every high phase of `dclk` lasts `div_cfg`+1 cycles, and no period is shorter than 2*(`div_cfg`+1) cycles. `ddata` does not change while `dclk` is high.
- R6: `s_ready` is high only in the data phase, between bytes, and while `dclk` is low. A byte accepted with `s_last` = 1 is the final one.
- R7: After the final byte, the block keeps pulsing `dclk` with `ddata` = 0. At each clock boundary it tests the synchronized `conf_done`. If `conf_done` is not seen within DONE_TMO cycles, the run ends with `error` = 2'b10 and `done_ok` = 0.
- R8: Once `conf_done` is seen, exactly WAKE_CLKS more pulses are issued with `ddata` = 0. The run then ends with `done_ok` = 1 and `error` = 2'b00.
- R9: `done_ok` and `error` hold until the next start. `error` is never 2'b11, and `done_ok` is never high together with a nonzero `error`.
- R10: During reset: `busy` = 0, `bus_rst_n` = 1, `cfg_req_n` = 1, `dclk` = 0, `s_ready` = 0, `done_ok` = 0 and `error` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins a configuration run |
| div_cfg | input | DIV_W | Data clock half period minus one, in system cycles |
| s_valid | input | 1 | Bitstream byte valid |
| s_data | input | 8 | Bitstream byte |
| s_last | input | 1 | Marks the final byte |
| s_ready | output | 1 | Loader accepts a byte |
| status_n | input | 1 | Active-low status from the target |
| conf_done | input | 1 | Configuration-done from the target |
| cfg_req_n | output | 1 | Active-low configuration request to the target |
| dclk | output | 1 | Serial data clock |
| ddata | output | 1 | Serial data bit |
| bus_rst_n | output | 1 | Active-low system bus reset |
| busy | output | 1 | A run is in progress |
| done_ok | output | 1 | Last run succeeded |
| error | output | 2 | 01 ready timeout, 10 done timeout |

## Verification
The bench builds the loader with LONG_DLY=6, SHORT_DLY=3, READY_TMO=24, DONE_TMO=80 and WAKE_CLKS=10. These short delays let both timeout paths and complete multi-byte runs fit into a few hundred cycles. A behavioural target model drops status late, so that the unbounded status-low wait is actually exercised. It raises `conf_done` on a chosen rising edge of `dclk`, either a few clocks into the trailing phase or on the last data bit itself, so the zero-length trailing case is covered. Divider values 1, 2 and 3 are used. With these values `conf_done` always reaches the synchronizer before the boundary that follows, so the wake-up pulse count can be checked exactly.

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
  parameter int LONG_DLY  = 1000,
  parameter int SHORT_DLY = 100,
  parameter int READY_TMO = 100000,
  parameter int DONE_TMO  = 100000,
  parameter int WAKE_CLKS = 10,
  parameter int DIV_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  input  logic             s_last,
  output logic             s_ready,
  input  logic             status_n,
  input  logic             conf_done,
  output logic             cfg_req_n,
  output logic             dclk,
  output logic             ddata,
  output logic             bus_rst_n,
  output logic             busy,
  output logic             done_ok,
  output logic [1:0]       error
);
  localparam int M1    = (LONG_DLY > SHORT_DLY) ? LONG_DLY : SHORT_DLY;
  localparam int M2    = (READY_TMO > DONE_TMO) ? READY_TMO : DONE_TMO;
  localparam int MAXC  = (M1 > M2) ? M1 : M2;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int WK_W  = $clog2(WAKE_CLKS + 1);
  localparam logic [CNT_W-1:0] LONG_END  = CNT_W'(LONG_DLY - 1);
  localparam logic [CNT_W-1:0] SHORT_END = CNT_W'(SHORT_DLY - 1);
  localparam logic [CNT_W-1:0] RDY_END   = CNT_W'(READY_TMO - 1);
  localparam logic [CNT_W-1:0] DONE_END  = CNT_W'(DONE_TMO - 1);
  localparam logic [WK_W-1:0]  WAKE_END  = WK_W'(WAKE_CLKS - 1);

  typedef enum logic [2:0] {
    IDLE, PRE_HI, REQ_LO, WAIT_LO, WAIT_HI, SHIFT, TRAIL, WAKE
  } state_t;

  state_t           st;
  logic [CNT_W-1:0] cnt;
  logic [DIV_W-1:0] div_q, hcnt;
  logic             ph;
  logic [7:0]       sreg;
  logic [3:0]       nbits;
  logic             last_q;
  logic [WK_W-1:0]  wk;
  logic [1:0]       stat_sy, done_sy;

  wire half_end = (hcnt == div_q);
  wire tick     = ph && half_end;
  wire boundary = !ph && (hcnt == '0);
  wire seen     = boundary && done_sy[1];
  wire run      = (st == SHIFT && nbits != 0) || st == WAKE ||
                  (st == TRAIL && !seen && cnt != DONE_END);

  assign s_ready   = (st == SHIFT) && (nbits == 0) && !last_q;
  assign cfg_req_n = !(st == REQ_LO || st == WAIT_LO);
  assign busy      = (st != IDLE);
  assign bus_rst_n = (st == IDLE);
  assign dclk      = ph;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stat_sy <= 2'b11;
      done_sy <= 2'b00;
    end else begin
      stat_sy <= {stat_sy[0], status_n};
      done_sy <= {done_sy[0], conf_done};
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      cnt     <= '0;
      div_q   <= '0;
      hcnt    <= '0;
      ph      <= 1'b0;
      sreg    <= '0;
      nbits   <= '0;
      last_q  <= 1'b0;
      wk      <= '0;
      ddata   <= 1'b0;
      done_ok <= 1'b0;
      error   <= 2'b00;
    end else begin
      if (run) begin
        if (half_end) begin
          hcnt <= '0;
          ph   <= ~ph;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
      case (st)
        IDLE: if (start) begin
          st      <= PRE_HI;
          cnt     <= '0;
          div_q   <= div_cfg;
          hcnt    <= '0;
          ph      <= 1'b0;
          nbits   <= '0;
          last_q  <= 1'b0;
          ddata   <= 1'b0;
          done_ok <= 1'b0;
          error   <= 2'b00;
        end
        PRE_HI:
          if (cnt == LONG_END) begin st <= REQ_LO; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        REQ_LO:
          if (cnt == SHORT_END) begin st <= WAIT_LO; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        WAIT_LO:
          if (!stat_sy[1]) begin st <= WAIT_HI; cnt <= '0; end
        WAIT_HI:
          if (stat_sy[1]) st <= SHIFT;
          else if (cnt == RDY_END) begin st <= IDLE; error <= 2'b01; end
          else cnt <= cnt + 1'b1;
        SHIFT:
          if (nbits == 0) begin
            if (last_q) begin
              st  <= TRAIL;
              cnt <= '0;
            end else if (s_valid) begin
              sreg   <= s_data;
              nbits  <= 4'd8;
              last_q <= s_last;
              ddata  <= s_data[0];
            end
          end else if (tick) begin
            nbits <= nbits - 1'b1;
            sreg  <= sreg >> 1;
            ddata <= (nbits == 4'd1) ? 1'b0 : sreg[1];
          end
        TRAIL:
          if (seen) begin
            st <= WAKE;
            wk <= '0;
          end else if (cnt == DONE_END) begin
            st    <= IDLE;
            error <= 2'b10;
            ph    <= 1'b0;
            hcnt  <= '0;
          end else cnt <= cnt + 1'b1;
        WAKE:
          if (tick) begin
            if (wk == WAKE_END) begin st <= IDLE; done_ok <= 1'b1; end
            else wk <= wk + 1'b1;
          end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module serial_cfg_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       s_ready,
  input logic       status_n,
  input logic       cfg_req_n,
  input logic       dclk,
  input logic       ddata,
  input logic       bus_rst_n,
  input logic       busy,
  input logic       done_ok,
  input logic [1:0] error
);
  // R1
  bus_reset_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready || dclk) |-> !bus_rst_n);
  // R5
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk && $past(dclk)) |-> $stable(ddata));
  // R6
  ready_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !dclk);
  // R9
  result_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |-> (error == 2'b00));
  // R9
  error_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error != 2'b11);
  // R3
  release_after_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cfg_req_n) && busy) |-> !$past(status_n, 2));
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $past(rst_n)) |-> ($stable(done_ok) && $stable(error)) || $past(busy));
endmodule

bind serial_cfg_loader serial_cfg_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .status_n(status_n),
  .cfg_req_n(cfg_req_n), .dclk(dclk), .ddata(ddata), .bus_rst_n(bus_rst_n),
  .busy(busy), .done_ok(done_ok), .error(error)
);

// File: tb/serial_cfg_loader_test.sv
module serial_cfg_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int LONG_DLY = 6, SHORT_DLY = 3, READY_TMO = 24, DONE_TMO = 80, WAKE_CLKS = 10;

  logic clk = 0, rst_n = 0, start = 0;
  logic [3:0] div_cfg = 0;
  logic s_valid = 0, s_last = 0;
  logic [7:0] s_data = 0;
  logic s_ready, status_n, conf_done, cfg_req_n, dclk, ddata, bus_rst_n, busy, done_ok;
  logic [1:0] error;

  serial_cfg_loader #(.LONG_DLY(LONG_DLY), .SHORT_DLY(SHORT_DLY), .READY_TMO(READY_TMO),
    .DONE_TMO(DONE_TMO), .WAKE_CLKS(WAKE_CLKS), .DIV_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .div_cfg(div_cfg), .s_valid(s_valid),
    .s_data(s_data), .s_last(s_last), .s_ready(s_ready), .status_n(status_n),
    .conf_done(conf_done), .cfg_req_n(cfg_req_n), .dclk(dclk), .ddata(ddata),
    .bus_rst_n(bus_rst_n), .busy(busy), .done_ok(done_ok), .error(error));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int drop_lat = 8, rise_lat = 4, done_at = 0, cur_div = 0;
  bit stat_ok = 1, done_en = 1;
  logic [7:0] bytes_q[$];
  logic bitq[$];
  int rises, wake_rises;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // target model: status and configuration-done
  int lo_cnt, rel_cnt;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      status_n <= 1; lo_cnt <= 0; rel_cnt <= 0;
    end else if (!cfg_req_n) begin
      lo_cnt <= lo_cnt + 1; rel_cnt <= 0;
      if (lo_cnt >= drop_lat) status_n <= 0;
    end else if (!status_n) begin
      rel_cnt <= rel_cnt + 1;
      if (rel_cnt >= rise_lat && stat_ok) status_n <= 1;
    end else lo_cnt <= 0;

  always @(posedge dclk or negedge rst_n)
    if (!rst_n) begin
      bitq.delete(); rises <= 0; wake_rises <= 0; conf_done <= 0;
    end else begin
      bitq.push_back(ddata);
      rises <= rises + 1;
      if (conf_done) wake_rises <= wake_rises + 1;
      if (done_en && rises + 1 == done_at) conf_done <= 1;
    end

  // per-cycle comparison against the behavioural model
  logic p_dclk, p_ddata, p_cfg;
  int hi_cnt, lo_len, stat_low, high_len, last_rise, ready_seen;
  bit seen_lo;
  always @(negedge clk)
    if (!rst_n) begin
      p_dclk = 0; p_ddata = 0; p_cfg = 1; hi_cnt = 0; lo_len = 0; stat_low = 0;
      high_len = 0; last_rise = -1; ready_seen = 0; seen_lo = 0;
    end else begin
      chk(bus_rst_n == !busy, "R1 bus reset", bus_rst_n, !busy);
      if (s_ready) begin
        ready_seen++;
        chk(dclk == 0, "R6 ready with clock low", dclk, 0);
      end
      if (dclk && p_dclk) chk(ddata == p_ddata, "R5 data stable", ddata, p_ddata);
      stat_low = status_n ? 0 : stat_low + 1;
      if (busy && cfg_req_n && !seen_lo) hi_cnt++;
      if (busy && !cfg_req_n && !seen_lo) begin
        seen_lo = 1;
        chk(hi_cnt == LONG_DLY, "R2 long high", hi_cnt, LONG_DLY);
      end
      if (!cfg_req_n) lo_len++;
      if (cfg_req_n && !p_cfg) begin
        chk(lo_len >= SHORT_DLY, "R2 short low", lo_len, SHORT_DLY);
        chk(stat_low >= 2, "R3 status low before release", stat_low, 2);
      end
      if (dclk) high_len++;
      if (dclk && !p_dclk) begin
        if (last_rise >= 0)
          chk(cyc - last_rise >= 2*(cur_div+1), "R5 period", cyc - last_rise, 2*(cur_div+1));
        last_rise = cyc;
      end
      if (!dclk && p_dclk) begin
        if (busy || done_ok) chk(high_len == cur_div+1, "R5 high phase", high_len, cur_div+1);
        high_len = 0;
      end
      p_dclk = dclk; p_ddata = ddata; p_cfg = cfg_req_n;
    end

  task automatic feed();
    for (int i = 0; i < bytes_q.size(); i++) begin
      @(negedge clk);
      s_valid = 1; s_data = bytes_q[i]; s_last = (i == bytes_q.size()-1);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
      s_valid = 0;
      repeat ((i % 2) ? 3 : 0) @(negedge clk);
    end
  endtask

  task automatic run_cfg(int div, int extra, bit sok, bit den, bit do_feed);
    rst_n = 0; stat_ok = sok; done_en = den; cur_div = div; div_cfg = 4'(div);
    done_at = 8*bytes_q.size() + extra;
    repeat (2) @(negedge clk);
    chk(!busy && bus_rst_n && cfg_req_n && !dclk && !s_ready, "R10 reset outputs",
        {busy, bus_rst_n, cfg_req_n, dclk, s_ready}, 5'b01100);
    chk(done_ok == 0 && error == 0, "R10 reset result", {done_ok, error}, 0);
    rst_n = 1;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    fork
      if (do_feed) feed();
      begin
        int n = 0;
        while (busy && n < 20000) begin @(negedge clk); n++; end
        chk(n < 20000, "R9 run ends", n, 20000);
      end
    join
  endtask

  task automatic check_bits(int nbits_exp, string req);
    chk(bitq.size() == nbits_exp, req, bitq.size(), nbits_exp);
    for (int i = 0; i < bitq.size(); i++) begin
      logic e;
      e = (i < 8*bytes_q.size()) ? bytes_q[i/8][i%8] : 1'b0;
      chk(bitq[i] === e, req, bitq[i], e);
    end
  endtask

  initial begin
    // run A: success with trailing clocks
    bytes_q = '{8'hA5, 8'h3C, 8'h01, 8'h80, 8'hFF};
    run_cfg(1, 3, 1, 1, 1);
    chk(done_ok == 1 && error == 0, "R8 success result", {done_ok, error}, 3'b100);
    chk(wake_rises == WAKE_CLKS, "R8 wake clocks", wake_rises, WAKE_CLKS);
    check_bits(8*5 + 3 + WAKE_CLKS, "R5 R7 bit stream");
    chk(bus_rst_n == 1, "R1 reset released", bus_rst_n, 1);
    repeat (5) @(negedge clk);
    chk(done_ok == 1 && error == 0 && !busy, "R9 result held", {done_ok, error}, 3'b100);

    // run B: done rises on last data bit, no trailing clocks
    bytes_q = '{8'h5A, 8'hC3, 8'h7E};
    run_cfg(3, 0, 1, 1, 1);
    chk(done_ok == 1 && error == 0, "R8 success result", {done_ok, error}, 3'b100);
    chk(wake_rises == WAKE_CLKS, "R8 wake clocks", wake_rises, WAKE_CLKS);
    check_bits(8*3 + WAKE_CLKS, "R5 R6 bit stream");

    // run C: ready timeout
    bytes_q = '{};
    run_cfg(1, 0, 0, 0, 0);
    chk(error == 2'b01 && done_ok == 0, "R4 ready timeout", {done_ok, error}, 3'b001);
    chk(rises == 0, "R4 no data clocks", rises, 0);
    chk(ready_seen == 0, "R6 no ready", ready_seen, 0);

    // run D: done timeout
    bytes_q = '{8'h96};
    run_cfg(2, 0, 1, 0, 1);
    chk(error == 2'b10 && done_ok == 0, "R7 done timeout", {done_ok, error}, 3'b010);
    chk(bitq.size() > 8, "R7 trailing clocks", bitq.size(), 9);
    check_bits(bitq.size(), "R7 zero trail");
    chk(bus_rst_n == 1 && dclk == 0, "R1 released after error", {bus_rst_n, dclk}, 2'b10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule